// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Register

This block is the slot control/status word of a root port that supports only two hot-plug events: a device arriving or leaving (presence) and the data link going up or down. Each of the two raw status inputs passes through a two-flop synchronizer. A change in either synchronized value latches a sticky flag. Software clears a flag by writing 1 to it.

Three read/write enable bits gate the flags onto one level-sensitive hot-plug interrupt: a master enable plus one enable per event. Every other hot-plug capability is hardwired to read as zero: buttons, indicators, power control, the latch sensor, the interlock and command completion. When the port has no slot, the presence bit reads as constant 1.

Software reaches the register through a plain one-cycle write port with a byte address and byte strobes. Read data is combinational from the byte address.

Top module: `hp_slot_reg`

## Requirements
- R1: After reset, the three enables and both change flags read 0 and `hp_irq` is 0. Reset alone never sets a change flag, even when an input is already 1 at reset.
- R2: Enable bits are read/write: bit 12 is the link-change enable, bit 5 the master interrupt enable and bit 3 the presence-change enable. Each is written only when its byte strobe is set (bit 12 uses `reg_be[1]`; bits 5 and 3 use `reg_be[0]`).
- R3: Every bit other than 24, 22, 19, 12, 5 and 3 always reads 0, and writes to those bits have no effect.
- R4: Bit 22 reads the synchronized `prsnt_in` when `slot_impl` is 1 (1 means a device is present) and reads constant 1 when `slot_impl` is 0.
- R5: Bit 19, the presence-changed flag, sets when the bit-22 value changes and stays set until it is cleared.
- R6: Bit 24, the link-changed flag, sets when the synchronized `link_up_in` changes and stays set until it is cleared.
- R7: A flag clears only on a write with a 1 in its bit and the matching strobe set (`reg_be[3]` for bit 24, `reg_be[2]` for bit 19). A write of 0 leaves the flag unchanged.
- R8: When a change event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: `hp_irq` is 1 exactly when bit 5 is 1 and either (bit 19 and bit 3) or (bit 24 and bit 12) are both 1.
- R10: An input change that is stable from a point between clock edges shows up in its flag after the third rising edge, and not after the second.
- R11: Only byte addresses inside the 32-bit word at `REG_ADDR` (default 0x58) select the register. Writes elsewhere are ignored, and reads elsewhere return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_impl | input | 1 | Static configuration: port has a slot |
| prsnt_in | input | 1 | Raw presence-detect level, asynchronous |
| link_up_in | input | 1 | Raw data-link-active level, asynchronous |
| reg_wr | input | 1 | Write request, one cycle per write |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_be | input | 4 | Byte write strobes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| hp_irq | output | 1 | Level hot-plug interrupt |

## Verification
The checker watches every cycle that unimplemented and reserved bits read zero, and that reads outside the word return zero. It also checks that the interrupt level always agrees with the flags and enables visible on the read port. Further cycle-by-cycle checks cover enable bits taking the strobed write data, flags holding without a clearing write, and the forced presence value when there is no slot. The synchronizer latency, the absence of spurious flags after reset and the set-over-clear collision depend on arranged input timing, so only the bench's directed scenarios can show them.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  typedef logic [31:0] hp_word_t;

  localparam int LNK_CHG_BIT     = 24;
  localparam int PRES_BIT        = 22;
  localparam int PRES_CHG_BIT    = 19;
  localparam int LNK_CHG_EN_BIT  = 12;
  localparam int MASTER_EN_BIT   = 5;
  localparam int PRES_CHG_EN_BIT = 3;

  // bits that carry state; all others read as zero
  localparam hp_word_t IMPL_MASK = hp_word_t'(32'h0148_1028);
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (i == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hp_arm_timer.sv
module hp_arm_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed = !cnt_en;
endmodule

// File: rtl/hp_chg_flag.sv
module hp_chg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic level,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic flag_q, flag_d;
  logic evt;

  assign evt = armed && (level != prev_q);

  // a change event outranks a same-cycle clear
  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/hp_slot_reg.sv
module hp_slot_reg
  import hp_slot_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 'h58,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_impl,
  input  logic              prsnt_in,
  input  logic              link_up_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              hp_irq
);
  // previous-value registers become valid one edge after the synchronizer fills
  localparam int ARM_CYCLES = SYNC_STAGES + 1;

  logic hit, wr_hit;
  logic [1:0] sync_q;
  logic link_s, prsnt_s, pres_val;
  logic armed;
  logic lnk_chg, pres_chg;
  logic lnk_clr, pres_clr;
  logic lce_q, lce_d, mie_q, mie_d, pce_q, pce_d;
  logic en_we;
  hp_word_t word;

  assign hit    = (reg_addr[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2]);
  assign wr_hit = reg_wr && hit;

  hp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({link_up_in, prsnt_in}),
    .q     (sync_q)
  );
  assign {link_s, prsnt_s} = sync_q;
  assign pres_val = slot_impl ? prsnt_s : 1'b1;

  hp_arm_timer #(.LIMIT(ARM_CYCLES)) u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed)
  );

  assign lnk_clr  = wr_hit && reg_be[LNK_CHG_BIT/8]  && reg_wdata[LNK_CHG_BIT];
  assign pres_clr = wr_hit && reg_be[PRES_CHG_BIT/8] && reg_wdata[PRES_CHG_BIT];

  hp_chg_flag u_lnk_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed),
    .level (link_s),
    .clr   (lnk_clr),
    .flag  (lnk_chg)
  );

  hp_chg_flag u_pres_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed),
    .level (pres_val),
    .clr   (pres_clr),
    .flag  (pres_chg)
  );

  // enable bits, written per byte strobe
  assign en_we = wr_hit && (reg_be[1:0] != 2'b00);

  always_comb begin
    lce_d = lce_q;
    mie_d = mie_q;
    pce_d = pce_q;
    if (reg_be[LNK_CHG_EN_BIT/8])  lce_d = reg_wdata[LNK_CHG_EN_BIT];
    if (reg_be[MASTER_EN_BIT/8])   mie_d = reg_wdata[MASTER_EN_BIT];
    if (reg_be[PRES_CHG_EN_BIT/8]) pce_d = reg_wdata[PRES_CHG_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lce_q <= 1'b0;
      mie_q <= 1'b0;
      pce_q <= 1'b0;
    end else if (en_we) begin
      lce_q <= lce_d;
      mie_q <= mie_d;
      pce_q <= pce_d;
    end
  end

  always_comb begin
    word                  = '0;
    word[LNK_CHG_BIT]     = lnk_chg;
    word[PRES_BIT]        = pres_val;
    word[PRES_CHG_BIT]    = pres_chg;
    word[LNK_CHG_EN_BIT]  = lce_q;
    word[MASTER_EN_BIT]   = mie_q;
    word[PRES_CHG_EN_BIT] = pce_q;
  end

  assign reg_rdata = hit ? word : '0;
  assign hp_irq    = mie_q && ((pres_chg && pce_q) || (lnk_chg && lce_q));
endmodule

// File: rtl/hp_slot_reg_chk.sv
module hp_slot_reg_chk
  import hp_slot_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h58
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_impl,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [3:0]        reg_be,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              hp_irq
);
  logic sel;
  assign sel = (reg_addr[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2]);

  // R3
  ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL_MASK) == 32'h0);

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> reg_rdata == 32'h0);

  // R4
  noslot_pres_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !slot_impl) |-> reg_rdata[PRES_BIT]);

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> hp_irq == (reg_rdata[MASTER_EN_BIT] &&
      ((reg_rdata[PRES_CHG_BIT] && reg_rdata[PRES_CHG_EN_BIT]) ||
       (reg_rdata[LNK_CHG_BIT] && reg_rdata[LNK_CHG_EN_BIT]))));

  // R2
  enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && sel && reg_be[1]) && sel) |->
      reg_rdata[LNK_CHG_EN_BIT] == $past(reg_wdata[LNK_CHG_EN_BIT]));

  // R5 R7
  pres_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && $past(reg_rdata[PRES_CHG_BIT]) &&
     !$past(reg_wr && reg_be[2] && reg_wdata[PRES_CHG_BIT])) |-> reg_rdata[PRES_CHG_BIT]);

  // R6 R7
  lnk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && $past(reg_rdata[LNK_CHG_BIT]) &&
     !$past(reg_wr && reg_be[3] && reg_wdata[LNK_CHG_BIT])) |-> reg_rdata[LNK_CHG_BIT]);
endmodule

bind hp_slot_reg hp_slot_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_impl (slot_impl),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_be    (reg_be),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hp_irq    (hp_irq)
);

// File: tb/hp_slot_reg_test.sv
`timescale 1ns/1ps
module hp_slot_reg_test;
  localparam logic [11:0] A = 12'h058;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_impl = 1'b1;
  logic        prsnt_in = 1'b0;
  logic        link_up_in = 1'b1;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = A;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        hp_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hp_slot_reg uut (
    .clk(clk), .rst_n(rst_n), .slot_impl(slot_impl), .prsnt_in(prsnt_in),
    .link_up_in(link_up_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hp_irq(hp_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0; reg_addr = A;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = A;
  endtask

  task automatic clear_all();
    wr(A, 4'hC, 32'h0108_0000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (6) @(negedge clk);
    rd(A, d);
    // R1: link_up_in was 1 through reset, yet no flag; presence 0
    chk("R1 reset word", d, 32'h0);
    chk("R1 reset irq", {31'h0, hp_irq}, 32'h0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(A, 4'h1, 32'hFFFF_FFFF);
    rd(A, d);
    chk("R2 byte0 enables", d, 32'h0000_0028);
    wr(A, 4'h2, 32'hFFFF_FFFF);
    rd(A, d);
    chk("R2 byte1 enable", d, 32'h0000_1028);
    wr(A, 4'hE, 32'h0);
    rd(A, d);
    chk("R2 strobe masks byte0", d, 32'h0000_0028);
    wr(A, 4'h1, 32'h0);
    rd(A, d);
    chk("R2 cleared", d, 32'h0);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(A, 4'hF, 32'hFFFF_FFFF);
    rd(A, d);
    chk("R3 ro bits stay zero", d, 32'h0000_1028);
    wr(A, 4'hF, 32'h0);
  endtask

  task automatic t_pres();
    logic [31:0] d;
    @(negedge clk); prsnt_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(A, d);
    chk("R10 pres flag not yet", {31'h0, d[19]}, 32'h0);
    chk("R4 pres bit follows input", {31'h0, d[22]}, 32'h1);
    @(negedge clk);
    rd(A, d);
    chk("R10 R5 pres flag set", {31'h0, d[19]}, 32'h1);
    repeat (5) @(negedge clk);
    rd(A, d);
    chk("R5 pres flag sticky", d, 32'h0048_0000);
    wr(A, 4'hB, 32'hFFFF_FFFF & ~32'h0000_1028);
    rd(A, d);
    chk("R7 no clear without strobe", {31'h0, d[19]}, 32'h1);
    wr(A, 4'h4, 32'h0);
    rd(A, d);
    chk("R7 write 0 keeps flag", {31'h0, d[19]}, 32'h1);
    wr(A, 4'h4, 32'h0008_0000);
    rd(A, d);
    chk("R7 write 1 clears pres flag", {31'h0, d[19]}, 32'h0);
  endtask

  task automatic t_link();
    logic [31:0] d;
    @(negedge clk); link_up_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(A, d);
    chk("R6 link flag set", {31'h0, d[24]}, 32'h1);
    wr(A, 4'h8, 32'h0100_0000);
    rd(A, d);
    chk("R7 link flag cleared", {31'h0, d[24]}, 32'h0);
    // R8: flag set, then a new change lands with a clear
    @(negedge clk); link_up_in = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); link_up_in = 1'b0;
    @(negedge clk); @(negedge clk);
    reg_be = 4'h8; reg_wdata = 32'h0100_0000; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
    rd(A, d);
    chk("R8 set wins over clear", {31'h0, d[24]}, 32'h1);
    clear_all();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A, 4'h1, 32'h0000_0008);
    @(negedge clk); prsnt_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no irq without master", {31'h0, hp_irq}, 32'h0);
    wr(A, 4'h1, 32'h0000_0028);
    #1 chk("R9 irq on pres", {31'h0, hp_irq}, 32'h1);
    clear_all();
    #1 chk("R9 irq drops after clear", {31'h0, hp_irq}, 32'h0);
    @(negedge clk); link_up_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 link flag without enable", {31'h0, hp_irq}, 32'h0);
    wr(A, 4'h2, 32'h0000_1000);
    #1 chk("R9 irq on link", {31'h0, hp_irq}, 32'h1);
    clear_all();
    wr(A, 4'h3, 32'h0);
    rd(A, d);
    chk("R9 idle word", d, 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(12'h05C, 4'hF, 32'hFFFF_FFFF);
    rd(A, d);
    chk("R11 other address write ignored", d, 32'h0);
    rd(12'h05C, d);
    chk("R11 other address reads 0", d, 32'h0);
    wr(12'h05A, 4'h1, 32'h0000_0020);
    rd(A, d);
    chk("R11 byte address inside word", d, 32'h0000_0020);
    wr(A, 4'h1, 32'h0);
  endtask

  task automatic t_noslot();
    logic [31:0] d;
    @(negedge clk); slot_impl = 1'b0;
    repeat (2) @(negedge clk);
    clear_all();
    @(negedge clk); prsnt_in = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk); prsnt_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(A, d);
    chk("R4 no slot reads present, no flag", d, 32'h0040_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_ro();
    t_pres();
    t_link();
    t_irq();
    t_decode();
    t_noslot();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule